// File: doc/BRIEF.md
# Interleaved Multi-Bank Shared Scratchpad

This block is a shared on-chip data memory for a group of parallel lanes. By default it holds 64 KB as 32 banks, and each bank is 512 rows of one 32-bit dword. A caller hands over one request vector at a time. The vector has a word per lane, and each word carries an enable, a write flag, a dword address and write data. Consecutive dword addresses fall in consecutive banks, so lanes that walk through memory with unit stride all land in different banks. A whole vector of that kind completes in one access cycle.

When lanes collide on a bank, the block splits the vector across several access cycles. In each cycle every bank serves one read and one write. The lowest-numbered lane that is still waiting goes first. Reads of one identical address are merged into a single bank read, and the word is broadcast to every lane that asked for it. Each lane's read result is registered. The block raises a one-cycle completion pulse once the last access of the vector has returned its data. A new vector is taken only while the block signals that it is idle.

Control is a four-state machine:
- IDLE: ready is high and the block waits.
- ISSUE: access cycles run, repeated while any lane is still pending.
- DRAIN: one cycle in which the final read data is captured.
- DONE: done is high for this single cycle.

The transitions are:
- ACCEPT: IDLE to ISSUE, when `req_valid` is seen in IDLE.
- RETRY: ISSUE to ISSUE, while lanes remain pending.
- FINISH: ISSUE to DRAIN, once no lane remains after this cycle's grants.
- CAPTURE: DRAIN to DONE.
- RELEASE: DONE to IDLE.

Top module: `sp_scratchpad`

## Requirements
- R1: A dword address selects its bank through its low log2(BANKS) bits (bits 4:0 by default) and its row through the remaining upper bits (bits 13:5 by default). Data written to an address is returned by a later read of the same address.
- R2: A vector in which no two lanes touch the same bank (identical-address reads excepted) needs one access cycle. `done` is then high on the third rising edge after the accepting edge.
- R3: Let N be the largest, over all banks, of the number of distinct addresses read in that bank and the number of writes to that bank. N is at least 1. `done` is high on the (N+2)th rising edge after the accepting edge.
- R4: Within a bank, the pending read with the lowest lane number is granted first, and so is the pending write with the lowest lane number. The lowest pending lane overall is granted in every access cycle.
- R5: Lanes that read one identical address are served by a single bank read. All of them receive the same word, and they add no access cycle.
- R6: When a read and a write to the same address are granted in the same cycle, the read returns the value held before that write.
- R7: When several lanes of a vector write the same address, the value of the highest of those lanes is the one that remains.
- R8: `ready` is high only in IDLE. `req_valid` has no effect while `ready` is low. `done` is high for exactly one cycle and is followed by `ready`. `ready` and `done` are never high together.
- R9: Lane l's result sits at `rsp_rdata[l*DW +: DW]`. It holds the read word for an enabled read lane and zero for a write lane or a disabled lane. The result stays unchanged from `done` until the next vector is accepted.
- R10: After reset, `ready` is 1, `done` is 0 and all of `rsp_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Present a request vector (taken only when ready) |
| req_en | input | LANES | Per-lane enable |
| req_we | input | LANES | Per-lane write flag (1 = write, 0 = read) |
| req_addr | input | LANES*AW | Per-lane dword address, lane l at [l*AW +: AW] |
| req_wdata | input | LANES*DW | Per-lane write data, lane l at [l*DW +: DW] |
| ready | output | 1 | Block is idle and will accept a vector |
| done | output | 1 | One-cycle pulse when the vector has fully completed |
| rsp_rdata | output | LANES*DW | Per-lane read result, lane l at [l*DW +: DW] |

## Verification
A wrong pending mask or a wrong grant shows up in two ways.

- Timing: `done` arrives on a different edge from the one the per-bank access count predicts. Every vector is timed, so this is caught as soon as that vector completes.
- Data: an error in arbitration order, broadcast merging or read-before-write returns a stale or foreign word in some lane. Memory contents are also modelled across vectors, so a misdirected write surfaces at the next read of the affected address, even though its own vector's timing looked correct.

// File: rtl/sp_pkg.sv
package sp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_DRAIN,
        ST_DONE
    } sp_state_e;
endpackage

// File: rtl/sp_bank.sv
module sp_bank #(
    parameter int DW   = 32,
    parameter int ROWS = 512,
    localparam int RW  = $clog2(ROWS)
) (
    input  logic          clk,
    input  logic          re,
    input  logic [RW-1:0] raddr,
    output logic [DW-1:0] rdata,
    input  logic          we,
    input  logic [RW-1:0] waddr,
    input  logic [DW-1:0] wdata
);
    logic [DW-1:0] mem [ROWS];

    // Separate read and write ports; non-blocking update gives old data on a same-row collision.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/sp_arbiter.sv
module sp_arbiter #(
    parameter int LANES = 32,
    parameter int BANKS = 32,
    parameter int ROWS  = 512,
    parameter int DW    = 32,
    localparam int BW   = $clog2(BANKS),
    localparam int RW   = $clog2(ROWS),
    localparam int AW   = BW + RW
) (
    input  logic [LANES-1:0]    pending,
    input  logic [LANES-1:0]    is_wr,
    input  logic [LANES*AW-1:0] addr_flat,
    input  logic [LANES*DW-1:0] wdata_flat,
    output logic [LANES-1:0]    rd_gnt,
    output logic [LANES-1:0]    wr_gnt,
    output logic [BANKS-1:0]    bank_re,
    output logic [BANKS-1:0]    bank_we,
    output logic [BANKS*RW-1:0] bank_rrow,
    output logic [BANKS*RW-1:0] bank_wrow,
    output logic [BANKS*DW-1:0] bank_wdata
);
    logic [BW-1:0] lane_bank [LANES];
    logic [RW-1:0] lane_row  [LANES];

    for (genvar l = 0; l < LANES; l++) begin : g_split
        assign lane_bank[l] = addr_flat[l*AW +: BW];
        assign lane_row[l]  = addr_flat[l*AW + BW +: RW];
    end

    // Per bank: the first pending read sets the row and later reads of that row join it;
    // the first pending write takes the write port. Ascending lane scan gives lowest-first.
    always_comb begin
        rd_gnt     = '0;
        wr_gnt     = '0;
        bank_re    = '0;
        bank_we    = '0;
        bank_rrow  = '0;
        bank_wrow  = '0;
        bank_wdata = '0;
        for (int b = 0; b < BANKS; b++) begin
            for (int l = 0; l < LANES; l++) begin
                if (pending[l] && (lane_bank[l] == BW'(b))) begin
                    if (!is_wr[l]) begin
                        if (!bank_re[b]) begin
                            bank_re[b]            = 1'b1;
                            bank_rrow[b*RW +: RW] = lane_row[l];
                            rd_gnt[l]             = 1'b1;
                        end else if (bank_rrow[b*RW +: RW] == lane_row[l]) begin
                            rd_gnt[l] = 1'b1;
                        end
                    end else if (!bank_we[b]) begin
                        bank_we[b]             = 1'b1;
                        bank_wrow[b*RW +: RW]  = lane_row[l];
                        bank_wdata[b*DW +: DW] = wdata_flat[l*DW +: DW];
                        wr_gnt[l]              = 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/sp_scratchpad.sv
module sp_scratchpad
    import sp_pkg::*;
#(
    parameter int LANES = 32,
    parameter int BANKS = 32,
    parameter int ROWS  = 512,
    parameter int DW    = 32,
    localparam int BW   = $clog2(BANKS),
    localparam int RW   = $clog2(ROWS),
    localparam int AW   = BW + RW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [LANES-1:0]    req_en,
    input  logic [LANES-1:0]    req_we,
    input  logic [LANES*AW-1:0] req_addr,
    input  logic [LANES*DW-1:0] req_wdata,
    output logic                ready,
    output logic                done,
    output logic [LANES*DW-1:0] rsp_rdata
);
    sp_state_e state_q, state_d;

    logic [LANES-1:0]    pend_q;
    logic [LANES-1:0]    we_q;
    logic [LANES*AW-1:0] addr_q;
    logic [LANES*DW-1:0] wdata_q;
    logic [LANES-1:0]    rgnt_q;

    logic                accept;
    logic                issuing;
    logic [LANES-1:0]    arb_pend;
    logic [LANES-1:0]    rd_gnt, wr_gnt;
    logic [LANES-1:0]    pend_next;
    logic [BANKS-1:0]    bank_re, bank_we;
    logic [BANKS*RW-1:0] bank_rrow, bank_wrow;
    logic [BANKS*DW-1:0] bank_wdata;
    logic [DW-1:0]       bank_rd [BANKS];

    assign accept    = (state_q == ST_IDLE) && req_valid;
    assign arb_pend  = issuing ? pend_q : '0;
    assign pend_next = pend_q & ~(rd_gnt | wr_gnt);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: ACCEPT, RETRY, FINISH, CAPTURE, RELEASE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_ISSUE;
            ST_ISSUE: if (pend_next == '0) state_d = ST_DRAIN;
            ST_DRAIN: state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State-decoded outputs
    always_comb begin
        ready   = 1'b0;
        done    = 1'b0;
        issuing = 1'b0;
        unique case (state_q)
            ST_IDLE:  ready   = 1'b1;
            ST_ISSUE: issuing = 1'b1;
            ST_DRAIN: ;
            ST_DONE:  done    = 1'b1;
            default:  ;
        endcase
    end

    // Vector latch and pending bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q  <= '0;
            we_q    <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            rgnt_q  <= '0;
        end else begin
            rgnt_q <= issuing ? rd_gnt : '0;
            if (accept) begin
                pend_q  <= req_en;
                we_q    <= req_we;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end else if (issuing) begin
                pend_q <= pend_next;
            end
        end
    end

    sp_arbiter #(
        .LANES(LANES), .BANKS(BANKS), .ROWS(ROWS), .DW(DW)
    ) u_arb (
        .pending    (arb_pend),
        .is_wr      (we_q),
        .addr_flat  (addr_q),
        .wdata_flat (wdata_q),
        .rd_gnt     (rd_gnt),
        .wr_gnt     (wr_gnt),
        .bank_re    (bank_re),
        .bank_we    (bank_we),
        .bank_rrow  (bank_rrow),
        .bank_wrow  (bank_wrow),
        .bank_wdata (bank_wdata)
    );

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        sp_bank #(.DW(DW), .ROWS(ROWS)) u_bank (
            .clk   (clk),
            .re    (bank_re[b]),
            .raddr (bank_rrow[b*RW +: RW]),
            .rdata (bank_rd[b]),
            .we    (bank_we[b]),
            .waddr (bank_wrow[b*RW +: RW]),
            .wdata (bank_wdata[b*DW +: DW])
        );
    end

    // Per-lane result registers: cleared on accept, loaded the cycle after a read grant
    for (genvar l = 0; l < LANES; l++) begin : g_res
        logic [DW-1:0] res;
        logic [BW-1:0] lbank;
        assign lbank = addr_q[l*AW +: BW];
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         res <= '0;
            else if (accept)    res <= '0;
            else if (rgnt_q[l]) res <= bank_rd[lbank];
        end
        assign rsp_rdata[l*DW +: DW] = res;
    end
endmodule

// File: rtl/sp_scratchpad_chk.sv
module sp_scratchpad_chk #(
    parameter int LANES = 32,
    parameter int DW    = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                ready,
    input logic                done,
    input logic                issuing,
    input logic [LANES-1:0]    pending,
    input logic [LANES-1:0]    rd_gnt,
    input logic [LANES-1:0]    wr_gnt,
    input logic [LANES*DW-1:0] rsp_rdata
);
    a_r8_ready_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(ready && done));

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_done_then_ready: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> ready);

    a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !req_valid) |=> $stable(rsp_rdata));

    a_r4_lowest_granted: assert property (@(posedge clk) disable iff (!rst_n)
        (issuing && (pending != '0)) |->
        (((pending & (~pending + LANES'(1))) & ~(rd_gnt | wr_gnt)) == '0));

    a_r3_grant_subset: assert property (@(posedge clk) disable iff (!rst_n)
        issuing |-> (((rd_gnt | wr_gnt) & ~pending) == '0));

    a_r3_no_dual_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_gnt & wr_gnt) == '0);
endmodule

bind sp_scratchpad sp_scratchpad_chk #(.LANES(LANES), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .ready     (ready),
    .done      (done),
    .issuing   (issuing),
    .pending   (pend_q),
    .rd_gnt    (rd_gnt),
    .wr_gnt    (wr_gnt),
    .rsp_rdata (rsp_rdata)
);

// File: tb/sp_scratchpad_tb_top.sv
`timescale 1ns/1ps
module sp_scratchpad_tb_top;
    localparam int L  = 4;
    localparam int B  = 4;
    localparam int R  = 8;
    localparam int DW = 32;
    localparam int BW = 2;
    localparam int AW = 5;
    localparam int NA = B * R;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic [L-1:0]    req_en = '0;
    logic [L-1:0]    req_we = '0;
    logic [L*AW-1:0] req_addr = '0;
    logic [L*DW-1:0] req_wdata = '0;
    logic            ready, done;
    logic [L*DW-1:0] rsp_rdata;

    always #10 clk = ~clk;

    sp_scratchpad #(.LANES(L), .BANKS(B), .ROWS(R), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_en(req_en),
        .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .ready(ready), .done(done), .rsp_rdata(rsp_rdata)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    logic [DW-1:0] mem_m [NA];
    logic [L-1:0]  v_en, v_we;
    logic [AW-1:0] v_addr [L];
    logic [DW-1:0] v_wd [L];
    logic [DW-1:0] exp_rd [L];
    int            exp_cyc;
    logic [31:0]   seed = 32'h1234_5678;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rnd(input logic [31:0] s);
        logic [31:0] x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    // Reference from the requirements: per bank, lowest pending read picks the address,
    // equal-address reads merge; lowest pending write commits after this cycle's reads.
    task automatic model();
        logic [L-1:0] pend = v_en;
        int n = 0;
        for (int l = 0; l < L; l++) exp_rd[l] = '0;
        while (pend != '0) begin
            logic [L-1:0] clr = '0;
            n++;
            for (int b = 0; b < B; b++) begin
                bit hr = 0;
                bit hw = 0;
                logic [AW-1:0] ra = '0;
                logic [AW-1:0] wa = '0;
                logic [DW-1:0] wd = '0;
                for (int l = 0; l < L; l++) begin
                    if (pend[l] && (int'(v_addr[l]) % B == b)) begin
                        if (!v_we[l]) begin
                            if (!hr) begin hr = 1; ra = v_addr[l]; end
                            if (v_addr[l] == ra) begin exp_rd[l] = mem_m[ra]; clr[l] = 1'b1; end
                        end else if (!hw) begin
                            hw = 1; wa = v_addr[l]; wd = v_wd[l]; clr[l] = 1'b1;
                        end
                    end
                end
                if (hw) mem_m[wa] = wd;
            end
            pend = pend & ~clr;
        end
        exp_cyc = (n == 0) ? 1 : n;
    endtask

    task automatic run_vec(input string req);
        int k;
        model();
        @(negedge clk);
        while (!ready) @(negedge clk);
        req_valid = 1'b1;
        req_en = v_en;
        req_we = v_we;
        for (int l = 0; l < L; l++) begin
            req_addr[l*AW +: AW]  = v_addr[l];
            req_wdata[l*DW +: DW] = v_wd[l];
        end
        @(negedge clk);
        req_valid = 1'b0;
        k = 1;
        while (!done && k < 100) begin
            @(negedge clk);
            k++;
        end
        check({req, " R3 done edge"}, k, exp_cyc + 2);
        for (int l = 0; l < L; l++)
            check({req, " R9 lane data"}, rsp_rdata[l*DW +: DW], exp_rd[l]);
        @(negedge clk);
        check({req, " R8 ready after done"}, {31'b0, ready}, 32'd1);
        check({req, " R9 held"}, rsp_rdata[0 +: DW], exp_rd[0]);
    endtask

    task automatic set_lane(input int l, input bit en, input bit we,
                            input logic [AW-1:0] a, input logic [DW-1:0] d);
        v_en[l] = en; v_we[l] = we; v_addr[l] = a; v_wd[l] = d;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NA; i++) mem_m[i] = '0;
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 ready", {31'b0, ready}, 32'd1);
        check("R10 done", {31'b0, done}, 32'd0);
        for (int l = 0; l < L; l++) check("R10 rsp", rsp_rdata[l*DW +: DW], '0);
        rst_n = 1'b1;

        // R2/R1: fill all addresses with conflict-free write vectors
        for (int v = 0; v < NA / L; v++) begin
            for (int l = 0; l < L; l++)
                set_lane(l, 1, 1, AW'(v*L + l), 32'hA000_0000 + 32'((v*L + l) * 77));
            run_vec("R2 fill");
        end
        // R1: read back every address, unit stride across banks
        for (int v = 0; v < NA / L; v++) begin
            for (int l = 0; l < L; l++) set_lane(l, 1, 0, AW'(v*L + l), '0);
            run_vec("R1 readback");
        end
        // R1/R3: same bank, four different rows -> four cycles
        for (int l = 0; l < L; l++) set_lane(l, 1, 0, AW'(l*B + 1), '0);
        run_vec("R1 same bank");
        // R5: broadcast of one address
        for (int l = 0; l < L; l++) set_lane(l, 1, 0, 5'd9, '0);
        run_vec("R5 broadcast");
        // R6: read and write of one address in one cycle
        set_lane(0, 1, 0, 5'd6, '0);
        set_lane(1, 1, 1, 5'd6, 32'hBEEF_0006);
        set_lane(2, 0, 0, 5'd0, '0);
        set_lane(3, 0, 0, 5'd0, '0);
        run_vec("R6 read before write");
        // R7: four writes to one address, then read back
        for (int l = 0; l < L; l++) set_lane(l, 1, 1, 5'd11, 32'hC0DE_0000 + 32'(l));
        run_vec("R7 writes");
        for (int l = 0; l < L; l++) set_lane(l, l == 2, 0, 5'd11, '0);
        run_vec("R7 readback");
        check("R7 last lane persists", exp_rd[2], 32'hC0DE_0003);
        // R4: ordering among colliders in bank 2
        set_lane(0, 1, 1, 5'd2, 32'h1111_0002);
        set_lane(1, 1, 0, 5'd2, '0);
        set_lane(2, 1, 1, 5'd2, 32'h2222_0002);
        set_lane(3, 1, 0, 5'd10, '0);
        run_vec("R4 order");
        for (int l = 0; l < L; l++) set_lane(l, 1, 0, 5'd2, '0);
        run_vec("R4 final");

        // R8: req_valid while busy has no effect
        for (int l = 0; l < L; l++) set_lane(l, 1, 0, AW'(l*B + 3), '0);
        model();
        @(negedge clk);
        while (!ready) @(negedge clk);
        req_valid = 1'b1; req_en = v_en; req_we = v_we;
        for (int l = 0; l < L; l++) req_addr[l*AW +: AW] = v_addr[l];
        @(negedge clk);
        req_en = '1; req_we = '1;
        for (int l = 0; l < L; l++) begin
            req_addr[l*AW +: AW] = 5'd13;
            req_wdata[l*DW +: DW] = 32'hDEAD_DEAD;
        end
        check("R8 ready low while busy", {31'b0, ready}, 32'd0);
        @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        for (int l = 0; l < L; l++)
            check("R8 busy vector data", rsp_rdata[l*DW +: DW], exp_rd[l]);
        for (int l = 0; l < L; l++) set_lane(l, l == 0, 0, 5'd13, '0);
        run_vec("R8 ignored write");

        // R3/R9: pseudo-random sweep over enables, directions and addresses
        for (int v = 0; v < 400; v++) begin
            for (int l = 0; l < L; l++) begin
                seed = rnd(seed);
                set_lane(l, seed[0] | seed[1], seed[2], seed[AW+7:8], rnd(seed ^ 32'h5A5A));
            end
            run_vec("R3 sweep");
        end

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule